// File: doc/BRIEF.md
# Timing reference fallback controller

This block chooses which timing source one board locks its clock to on a shared backplane clock bus. Six candidate sources each arrive with a valid indication: a local digital trunk, two shared reference lines, the on-board oscillator, and the two bus clocks A and B. A loss filter counts reference periods (marked by a tick strobe) while a source reads invalid. A source is treated as lost only after it stays invalid for a programmable number of periods.

The board's role sets the switching rules. A primary master moves to its fallback when its primary reference fails and moves back by itself once the primary recovers. A secondary master and a slave move to the fallback the same way, but then stay there until software pulses the clear input. A master also drives one bus clock. A standalone board runs from its oscillator, drives nothing and reports that it is detached from the bus. An inconsistent configuration is flagged and pins the selection to the primary source. Every change of the selected code produces a one-cycle event pulse.

Top module: `tref_sel_top`

## Requirements
- R1: During and right after reset, selSrc is 0 and fbActive, holdover, driveA, driveB, busDetached, cfgError and swEvent are all low.
- R2: A source counts as lost only after srcValid for that bit has been low across lossLimit consecutive cycles in which refTick is high. Any valid cycle restarts the count. Cycles with refTick low do not advance it, so a shorter invalid span causes no switch.
- R3: In role 0 (primary master) with cfgAutoFb high, losing the primary while the fallback is valid selects cfgFallback and raises fbActive. When the primary becomes valid again, the block reselects cfgPrimary and clears fbActive without software action.
- R4: With cfgAutoFb low, a lost primary never causes a switch; selSrc stays cfgPrimary and fbActive stays low.
- R5: In role 1 (secondary master) the primary must be a bus clock. The block drives the other bus clock in both the normal and the fallback state. After it falls back it keeps the fallback even when the primary returns, until swClear is pulsed.
- R6: In role 2 (slave), driveA and driveB stay low. On loss of the primary bus clock the block selects the fallback bus clock and holds it until swClear is pulsed.
- R7: In role 3 (standalone), selSrc is 3 (oscillator), driveA and driveB are low and busDetached is high.
- R8: cfgError goes high, fbActive stays low and selSrc stays cfgPrimary in any non-standalone role when any of these holds: the fallback equals the primary; either code exceeds 5; code 2 is used while cfgDualRef is low; or the bus-clock rules of the role are broken. Those rules are: role 0 may not use codes 4 or 5; role 1 needs a primary of 4 or 5 and a non-bus fallback; role 2 needs both to be 4 or 5. While cfgError is high, both drive enables are low.
- R9: swEvent is high for exactly one cycle each time selSrc takes a new value, in the cycle the new value first appears. The first load after reset produces no pulse.
- R10: In roles 0 and 1, when both the primary and the fallback are lost, holdover goes high and both drive enables go low. They recover when either source returns.
- R11: Source codes are 0 trunk, 1 reference line 1, 2 reference line 2, 3 oscillator, 4 bus clock A, 5 bus clock B. In role 0, cfgDriveB low drives bus A only and high drives bus B only. driveA and driveB are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle strobe marking a reference period |
| srcValid | input | 6 | Valid indication per source, bit index equals source code |
| lossLimit | input | CW | Reference periods of invalidity before a source counts as lost |
| cfgRole | input | 2 | 0 primary master, 1 secondary master, 2 slave, 3 standalone |
| cfgPrimary | input | 3 | Primary source code |
| cfgFallback | input | 3 | Fallback source code |
| cfgAutoFb | input | 1 | Auto-fallback enable |
| cfgDualRef | input | 1 | Second reference line present |
| cfgDriveB | input | 1 | Primary master drives bus B instead of A |
| swClear | input | 1 | Software release of a latched fallback |
| selSrc | output | 3 | Selected source code |
| swEvent | output | 1 | One-cycle pulse on a change of selSrc |
| fbActive | output | 1 | Fallback reference selected |
| holdover | output | 1 | Master with both references lost |
| driveA | output | 1 | Drive enable for bus clock A |
| driveB | output | 1 | Drive enable for bus clock B |
| busDetached | output | 1 | Standalone, board not on the bus |
| cfgError | output | 1 | Configuration rejected |

## Verification
The hardest state to reach is a latched fallback that must survive the return of its primary. Reaching it takes a filtered loss long enough to pass the period count, then a recovery, and only after that a clear pulse. The stimulus runs this sequence for the secondary-master and slave roles, and runs the same recovery for the primary master, where the block must revert on its own. A second hard case is a loss span one period short of the limit, or a long span with the period strobe held low; the bench expects both to leave the selection and the event count unchanged.

// File: rtl/tref_pkg.sv
package tref_pkg;
  localparam int NSRC = 6;
  localparam int SW = 3;

  typedef enum logic [SW-1:0] {
    SRC_TRUNK = 3'd0,
    SRC_REF1  = 3'd1,
    SRC_REF2  = 3'd2,
    SRC_OSC   = 3'd3,
    SRC_BUSA  = 3'd4,
    SRC_BUSB  = 3'd5
  } src_e;

  typedef enum logic [1:0] {
    ROLE_PRI   = 2'd0,
    ROLE_SEC   = 2'd1,
    ROLE_SLV   = 2'd2,
    ROLE_ALONE = 2'd3
  } role_e;

  typedef enum logic {
    ST_NORM = 1'b0,
    ST_FALL = 1'b1
  } fallSt_e;

  typedef struct packed {
    logic useFb;
    logic useOsc;
    logic drvA;
    logic drvB;
    logic hold;
    logic err;
  } strobe_t;
endpackage

// File: rtl/tref_loss.sv
module tref_loss #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refTick,
  input  logic          valid,
  input  logic [CW-1:0] limit,
  output logic          lost
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (valid) cnt <= '0;
    else if (refTick && (cnt < limit)) cnt <= cnt + 1'b1;
  end

  assign lost = !valid && (cnt >= limit);

  AST_LOST_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rstN)
    (lost && limit != '0) |-> $past(!valid)) else $error("loss without prior invalid"); // R2
endmodule

// File: rtl/tref_ctrl.sv
module tref_ctrl
  import tref_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcLost,
  input  logic [1:0]      cfgRole,
  input  logic [SW-1:0]   cfgPrimary,
  input  logic [SW-1:0]   cfgFallback,
  input  logic            cfgAutoFb,
  input  logic            cfgDualRef,
  input  logic            cfgDriveB,
  input  logic            swClear,
  output strobe_t         stb
);
  localparam int PADW = 1 << SW;
  localparam logic [SW-1:0] LASTCODE = SW'(NSRC - 1);

  logic [PADW-1:0] lostPad;
  logic priLost, fbLost, priIsBus, fbIsBus;
  logic codeBad, sameSrc, refBad, roleBad, errNext;
  logic isMaster, holdNext, drvANext, drvBNext;
  fallSt_e stQ, stNext;
  logic holdQ, errQ, drvAQ, drvBQ, aloneQ;

  assign lostPad  = {{(PADW-NSRC){1'b1}}, srcLost};
  assign priLost  = lostPad[cfgPrimary];
  assign fbLost   = lostPad[cfgFallback];
  assign priIsBus = (cfgPrimary == SRC_BUSA) || (cfgPrimary == SRC_BUSB);
  assign fbIsBus  = (cfgFallback == SRC_BUSA) || (cfgFallback == SRC_BUSB);
  assign codeBad  = (cfgPrimary > LASTCODE) || (cfgFallback > LASTCODE);
  assign sameSrc  = (cfgPrimary == cfgFallback);
  assign refBad   = !cfgDualRef && ((cfgPrimary == SRC_REF2) || (cfgFallback == SRC_REF2));
  assign isMaster = (cfgRole == ROLE_PRI) || (cfgRole == ROLE_SEC);

  always_comb begin
    case (cfgRole)
      ROLE_PRI: roleBad = priIsBus || fbIsBus;
      ROLE_SEC: roleBad = !priIsBus || fbIsBus;
      ROLE_SLV: roleBad = !priIsBus || !fbIsBus;
      default:  roleBad = 1'b0;
    endcase
  end

  assign errNext = (cfgRole != ROLE_ALONE) && (codeBad || sameSrc || refBad || roleBad);

  always_comb begin
    stNext = stQ;
    if ((cfgRole == ROLE_ALONE) || errNext) stNext = ST_NORM;
    else if (stQ == ST_NORM) begin
      if (cfgAutoFb && priLost && !fbLost) stNext = ST_FALL;
    end
    else if (swClear) stNext = ST_NORM;
    else if ((cfgRole == ROLE_PRI) && !priLost) stNext = ST_NORM;
  end

  assign holdNext = isMaster && !errNext && priLost && fbLost;
  assign drvANext = !holdNext && !errNext &&
                    (((cfgRole == ROLE_PRI) && !cfgDriveB) ||
                     ((cfgRole == ROLE_SEC) && (cfgPrimary == SRC_BUSB)));
  assign drvBNext = !holdNext && !errNext &&
                    (((cfgRole == ROLE_PRI) && cfgDriveB) ||
                     ((cfgRole == ROLE_SEC) && (cfgPrimary == SRC_BUSA)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ    <= ST_NORM;
      holdQ  <= 1'b0;
      errQ   <= 1'b0;
      drvAQ  <= 1'b0;
      drvBQ  <= 1'b0;
      aloneQ <= 1'b0;
    end else begin
      stQ    <= stNext;
      holdQ  <= holdNext;
      errQ   <= errNext;
      drvAQ  <= drvANext;
      drvBQ  <= drvBNext;
      aloneQ <= (cfgRole == ROLE_ALONE);
    end
  end

  assign stb = '{useFb: (stQ == ST_FALL), useOsc: aloneQ, drvA: drvAQ,
                 drvB: drvBQ, hold: holdQ, err: errQ};

  AST_NO_SWITCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_NORM && !cfgAutoFb) |=> (stQ == ST_NORM)) else $error("switch with auto off"); // R4
  AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_FALL && (cfgRole == ROLE_SEC || cfgRole == ROLE_SLV) && !swClear && !errNext)
    |=> (stQ == ST_FALL)) else $error("latched fallback released"); // R5
  AST_PRI_REVERTS: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_FALL && cfgRole == ROLE_PRI && !priLost) |=> (stQ == ST_NORM)) else $error("no revert"); // R3
endmodule

// File: rtl/tref_dp.sv
module tref_dp
  import tref_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refTick,
  input  logic [NSRC-1:0] srcValid,
  input  logic [CW-1:0]   lossLimit,
  input  logic [SW-1:0]   cfgPrimary,
  input  logic [SW-1:0]   cfgFallback,
  input  strobe_t         stb,
  output logic [NSRC-1:0] srcLost,
  output logic [SW-1:0]   selSrc,
  output logic            swEvent,
  output logic            fbActive,
  output logic            holdover,
  output logic            driveA,
  output logic            driveB,
  output logic            busDetached,
  output logic            cfgError
);
  logic [SW-1:0] selNext;
  logic primedQ;

  for (genvar i = 0; i < NSRC; i++) begin : g_loss
    tref_loss #(.CW(CW)) loss_i (
      .clk(clk), .rstN(rstN), .refTick(refTick), .valid(srcValid[i]),
      .limit(lossLimit), .lost(srcLost[i])
    );
  end

  always_comb begin
    if (stb.useOsc) selNext = SRC_OSC;
    else if (stb.useFb) selNext = cfgFallback;
    else selNext = cfgPrimary;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selSrc      <= '0;
      swEvent     <= 1'b0;
      primedQ     <= 1'b0;
      fbActive    <= 1'b0;
      holdover    <= 1'b0;
      driveA      <= 1'b0;
      driveB      <= 1'b0;
      busDetached <= 1'b0;
      cfgError    <= 1'b0;
    end else begin
      selSrc      <= selNext;
      swEvent     <= primedQ && (selNext != selSrc);
      primedQ     <= 1'b1;
      fbActive    <= stb.useFb;
      holdover    <= stb.hold;
      driveA      <= stb.drvA;
      driveB      <= stb.drvB;
      busDetached <= stb.useOsc;
      cfgError    <= stb.err;
    end
  end

  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(driveA && driveB)) else $error("both buses driven"); // R11
  AST_EVENT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    swEvent |-> (selSrc != $past(selSrc))) else $error("event without change"); // R9
  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    swEvent |=> !swEvent || (selSrc != $past(selSrc))) else $error("stretched event"); // R9
  AST_DETACH_NODRIVE: assert property (@(posedge clk) disable iff (!rstN)
    busDetached |-> (!driveA && !driveB && selSrc == SRC_OSC)) else $error("standalone drives"); // R7
  AST_ERR_NO_FB: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!fbActive && !driveA && !driveB)) else $error("fallback under error"); // R8
  AST_HOLD_NODRIVE: assert property (@(posedge clk) disable iff (!rstN)
    holdover |-> (!driveA && !driveB)) else $error("drive in holdover"); // R10
endmodule

// File: rtl/tref_sel_top.sv
module tref_sel_top
  import tref_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refTick,
  input  logic [NSRC-1:0] srcValid,
  input  logic [CW-1:0]   lossLimit,
  input  logic [1:0]      cfgRole,
  input  logic [SW-1:0]   cfgPrimary,
  input  logic [SW-1:0]   cfgFallback,
  input  logic            cfgAutoFb,
  input  logic            cfgDualRef,
  input  logic            cfgDriveB,
  input  logic            swClear,
  output logic [SW-1:0]   selSrc,
  output logic            swEvent,
  output logic            fbActive,
  output logic            holdover,
  output logic            driveA,
  output logic            driveB,
  output logic            busDetached,
  output logic            cfgError
);
  logic [NSRC-1:0] srcLost;
  strobe_t stb;

  tref_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .srcLost(srcLost), .cfgRole(cfgRole),
    .cfgPrimary(cfgPrimary), .cfgFallback(cfgFallback), .cfgAutoFb(cfgAutoFb),
    .cfgDualRef(cfgDualRef), .cfgDriveB(cfgDriveB), .swClear(swClear), .stb(stb)
  );

  tref_dp #(.CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .srcValid(srcValid),
    .lossLimit(lossLimit), .cfgPrimary(cfgPrimary), .cfgFallback(cfgFallback),
    .stb(stb), .srcLost(srcLost), .selSrc(selSrc), .swEvent(swEvent),
    .fbActive(fbActive), .holdover(holdover), .driveA(driveA), .driveB(driveB),
    .busDetached(busDetached), .cfgError(cfgError)
  );
endmodule

// File: tb/tref_sel_top_tb_top.sv
module tref_sel_top_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN;
  logic refTick;
  logic [5:0] srcValid;
  logic [CW-1:0] lossLimit;
  logic [1:0] cfgRole;
  logic [2:0] cfgPrimary, cfgFallback;
  logic cfgAutoFb, cfgDualRef, cfgDriveB, swClear;
  logic [2:0] selSrc;
  logic swEvent, fbActive, holdover, driveA, driveB, busDetached, cfgError;

  typedef struct {
    logic [8:0] flags;
    int ev;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int failed = 0;
  int evCount = 0;
  logic prevEvent = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tref_sel_top #(.CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .srcValid(srcValid),
    .lossLimit(lossLimit), .cfgRole(cfgRole), .cfgPrimary(cfgPrimary),
    .cfgFallback(cfgFallback), .cfgAutoFb(cfgAutoFb), .cfgDualRef(cfgDualRef),
    .cfgDriveB(cfgDriveB), .swClear(swClear), .selSrc(selSrc), .swEvent(swEvent),
    .fbActive(fbActive), .holdover(holdover), .driveA(driveA), .driveB(driveB),
    .busDetached(busDetached), .cfgError(cfgError)
  );

  // Monitor: counts event pulses, then compares queued expectations.
  always @(negedge clk) begin
    logic [8:0] act;
    if (rstN && swEvent) evCount++;
    if (rstN && swEvent && prevEvent) begin
      total++;
      failed++;
      $display("FAIL R9 event pulse wider than one cycle: actual 2 cycles expected 1");
    end
    prevEvent = rstN && swEvent;
    act = {selSrc, fbActive, holdover, driveA, driveB, busDetached, cfgError};
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (act !== e.flags || evCount != e.ev) begin
        failed++;
        $display("FAIL %s sel/fb/hold/dA/dB/det/err actual %b ev %0d expected %b ev %0d",
                 e.tag, act, evCount, e.flags, e.ev);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectItem(input logic [2:0] s, input logic fb, input logic h,
                            input logic a, input logic b, input logic d,
                            input logic er, input int ev, input string tag);
    exp_t e;
    e.flags = {s, fb, h, a, b, d, er};
    e.ev = ev;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    rstN = 1'b0; refTick = 1'b1; srcValid = 6'h3F; lossLimit = 8'd3;
    cfgRole = 2'd0; cfgPrimary = 3'd1; cfgFallback = 3'd0;
    cfgAutoFb = 1'b1; cfgDualRef = 1'b0; cfgDriveB = 1'b0; swClear = 1'b0;
    settle(3);
    expectItem(3'd0, 0, 0, 0, 0, 0, 0, 0, "R1 reset state");
    settle(1);
    rstN = 1'b1;
    settle(8);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 0, "R11 primary master on ref1 drives A, R1 no event");

    // R2 short glitch ignored
    srcValid[1] = 1'b0; settle(2); srcValid[1] = 1'b1; settle(8);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 0, "R2 two-period loss ignored");

    // R2 no ticks, no count
    refTick = 1'b0; srcValid[1] = 1'b0; settle(10);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 0, "R2 loss without ticks ignored");
    refTick = 1'b1; settle(8);
    expectItem(3'd0, 1, 0, 1, 0, 0, 0, 1, "R3 fallback to trunk");

    srcValid[1] = 1'b1; settle(8);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 2, "R3 self revert, R9 second event");

    // R10 holdover
    srcValid[1] = 1'b0; srcValid[0] = 1'b0; settle(8);
    expectItem(3'd1, 0, 1, 0, 0, 0, 0, 2, "R10 holdover both lost");
    srcValid = 6'h3F; settle(8);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 2, "R10 holdover recovery");

    // R4 auto off
    cfgAutoFb = 1'b0; srcValid[1] = 1'b0; settle(10);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 2, "R4 no switch with auto off");
    srcValid[1] = 1'b1; cfgAutoFb = 1'b1; settle(8);

    cfgDriveB = 1'b1; settle(4);
    expectItem(3'd1, 0, 0, 0, 1, 0, 0, 2, "R11 primary master drives B");
    cfgDriveB = 1'b0; settle(4);

    // R8 config errors
    cfgFallback = 3'd1; srcValid[1] = 1'b0; settle(8);
    expectItem(3'd1, 0, 0, 0, 0, 0, 1, 2, "R8 fallback equals primary");
    srcValid[1] = 1'b1; cfgFallback = 3'd2; settle(4);
    expectItem(3'd1, 0, 0, 0, 0, 0, 1, 2, "R8 ref2 without dual ref");
    cfgDualRef = 1'b1; settle(4);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 2, "R8 ref2 accepted with dual ref");
    cfgFallback = 3'd4; settle(4);
    expectItem(3'd1, 0, 0, 0, 0, 0, 1, 2, "R8 primary master with bus fallback");
    cfgFallback = 3'd0; cfgDualRef = 1'b0; settle(4);

    // R5 secondary master
    cfgRole = 2'd1; cfgPrimary = 3'd4; cfgFallback = 3'd0; settle(8);
    expectItem(3'd4, 0, 0, 0, 1, 0, 0, 3, "R5 secondary on bus A drives B");
    srcValid[4] = 1'b0; settle(8);
    expectItem(3'd0, 1, 0, 0, 1, 0, 0, 4, "R5 secondary fallback still drives B");
    srcValid[4] = 1'b1; settle(10);
    expectItem(3'd0, 1, 0, 0, 1, 0, 0, 4, "R5 secondary latched after bus returns");
    swClear = 1'b1; settle(1); swClear = 1'b0; settle(8);
    expectItem(3'd4, 0, 0, 0, 1, 0, 0, 5, "R5 software clear releases");

    // R6 slave
    cfgRole = 2'd2; cfgFallback = 3'd5; settle(8);
    expectItem(3'd4, 0, 0, 0, 0, 0, 0, 5, "R6 slave drives nothing");
    srcValid[4] = 1'b0; settle(8);
    expectItem(3'd5, 1, 0, 0, 0, 0, 0, 6, "R6 slave falls to bus B");
    srcValid[4] = 1'b1; settle(10);
    expectItem(3'd5, 1, 0, 0, 0, 0, 0, 6, "R6 slave latched");
    swClear = 1'b1; settle(1); swClear = 1'b0; settle(8);
    expectItem(3'd4, 0, 0, 0, 0, 0, 0, 7, "R6 slave cleared");

    // R7 standalone
    cfgRole = 2'd3; settle(8);
    expectItem(3'd3, 0, 0, 0, 0, 1, 0, 8, "R7 standalone on oscillator");
    cfgRole = 2'd0; cfgPrimary = 3'd1; cfgFallback = 3'd0; settle(8);
    expectItem(3'd1, 0, 0, 1, 0, 0, 0, 9, "R9 return to primary master");
    settle(3);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired: actual hung expected done");
    end
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule